// File: doc/BRIEF.md
# Exponential programmable delay timer

This block produces a software-timed wait whose length is a fixed base count scaled by a power of two. Software writes a single 32-bit control word that holds a go bit and a 3-bit exponent. The block then counts `BASE_COUNT << exponent` clock cycles. With the default base of 50 cycles, the wait ranges from 50 to 6400 cycles.

When the count runs out, the block sets a completion flag in the same word. Software polls that flag through the read port. The flag stays set until the next go write, so a late poll still sees it.

A go write that arrives while a wait is in progress abandons that wait. It starts a fresh one with the newly written exponent, timed from the new write. A write whose go bit is clear changes nothing.

Top module: `exp_delay_timer`

## Requirements
- R1: While `rst` is high at a rising edge, all state is cleared, and after that edge `rd_data` reads 0.
- R2: `rd_data` bit 16 reads 1 while a wait is in progress, bits 19..17 return the exponent of the last go write, bit 20 is the completion flag, and every other bit reads 0.
- R3: A write with `wr_data` bit 16 set (a go write) starts a wait of N = 50 << E cycles, where E = `wr_data` bits 19..17. After the edge that captures the write plus N-1 further edges, bit 20 reads 0 and bit 16 reads 1. After N further edges, bit 20 reads 1.
- R4: The exponent covers the full range 0 to 7, giving waits of 50 cycles at E=0 and 6400 cycles at E=7.
- R5: The busy bit (bit 16) clears on the same edge that sets the completion flag. The flag then holds at 1 with no further writes.
- R6: A go write clears the completion flag on the edge that captures it.
- R7: A go write during a wait restarts the count with the new exponent, timed from the new write.
- R8: A write with bit 16 clear leaves the exponent, the completion flag and any wait in progress unchanged. The bits of a go write other than 16..19 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word: bit 16 go, bits 19..17 exponent |
| rd_data | output | 32 | Status word: bit 16 busy, bits 19..17 exponent, bit 20 done |

## Verification
The read port is combinational from state, so the exponent, the busy bit and the cleared flag appear one edge after the edge that captures a go write. The completion flag is due exactly N edges after that capture edge.

The bench drives and samples on falling edges and counts edges from the capture edge. For each exponent it checks for a 0 after N-1 edges and a 1 after N edges, which pins the delay to a single cycle. Restart and ignored-write scenarios are timed the same way, from the last go write.

// File: rtl/dly_timer_pkg.sv
package dly_timer_pkg;

    localparam int DLY_EXP_W  = 3;
    localparam int DLY_WORD_W = 32;
    localparam int GO_POS     = 16;
    localparam int EXP_LO     = 17;
    localparam int DONE_POS   = 20;

    typedef logic [DLY_EXP_W-1:0] dly_exp_t;

    typedef struct packed {
        logic     go;
        dly_exp_t exp;
    } dly_cmd_t;

    // Packed order matches the status word bits 20..16
    typedef struct packed {
        logic     done;
        dly_exp_t exp;
        logic     busy;
    } dly_stat_t;

    function automatic dly_cmd_t dly_decode(input logic [DLY_WORD_W-1:0] w);
        dly_cmd_t c;
        c.go  = w[GO_POS];
        c.exp = w[EXP_LO +: DLY_EXP_W];
        return c;
    endfunction

    function automatic logic [DLY_WORD_W-1:0] dly_pack(input dly_stat_t s);
        logic [DLY_WORD_W-1:0] w;
        w = '0;
        w[GO_POS +: $bits(dly_stat_t)] = s;
        return w;
    endfunction

endpackage

// File: rtl/dly_ctrl.sv
module dly_ctrl
    import dly_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  dly_cmd_t cmd,
    input  logic     expire,
    output logic     load,
    output dly_exp_t exp_q,
    output logic     done_q
);

    assign load = wr_en & cmd.go;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q  <= '0;
            done_q <= 1'b0;
        end else if (load) begin
            exp_q  <= cmd.exp;
            done_q <= 1'b0;
        end else if (expire) begin
            done_q <= 1'b1;
        end
    end

    // R6: a go write clears the flag
    a_r6_done_clears: assert property (@(posedge clk) disable iff (rst)
        load |=> !done_q);

    // R5: the flag is sticky without a go write
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done_q && !load |=> done_q);

    // R3: expiry raises the flag
    a_r3_expire_sets: assert property (@(posedge clk) disable iff (rst)
        expire |=> done_q);

    // R8: the exponent only changes on a go write
    a_r8_exp_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> exp_q == $past(exp_q));

endmodule

// File: rtl/dly_downcount.sv
module dly_downcount #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] span,
    output logic             running,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= span - CNT_W'(1);
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - CNT_W'(1);
        end
    end

    assign expire = running & (cnt == '0) & ~load;

    // R3 / R7: a load (restart included) reloads the full span
    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        load |=> running && (cnt == $past(span) - CNT_W'(1)));

    // R3: one step per cycle while running
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        running && (cnt != '0) && !load |=> running && (cnt == $past(cnt) - CNT_W'(1)));

    // R5: busy drops when the count expires
    a_r5_busy_drop: assert property (@(posedge clk) disable iff (rst)
        expire |=> !running);

endmodule

// File: rtl/exp_delay_timer.sv
module exp_delay_timer
    import dly_timer_pkg::*;
#(
    parameter int BASE_COUNT = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data
);

    localparam int MAX_SPAN = BASE_COUNT << ((1 << DLY_EXP_W) - 1);
    localparam int CNT_W    = $clog2(MAX_SPAN + 1);

    dly_cmd_t         cmd;
    logic             load;
    logic             expire;
    logic             running;
    logic             done_q;
    dly_exp_t         exp_q;
    logic [CNT_W-1:0] span;
    dly_stat_t        stat;

    assign cmd  = dly_decode(wr_data);
    assign span = CNT_W'(BASE_COUNT) << cmd.exp;

    // Bits outside the control fields are intentionally dropped (R8)
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[31:21], wr_data[20], wr_data[15:0]};

    dly_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .cmd    (cmd),
        .expire (expire),
        .load   (load),
        .exp_q  (exp_q),
        .done_q (done_q)
    );

    dly_downcount #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .span    (span),
        .running (running),
        .expire  (expire)
    );

    always_comb begin
        stat.done = done_q;
        stat.exp  = exp_q;
        stat.busy = running;
    end

    assign rd_data = dly_pack(stat);

    // R1: reset leaves a zero status word
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> rd_data == '0);

    // R2 / R5: busy and done are never both set
    a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(rd_data[GO_POS] && rd_data[DONE_POS]));

endmodule

// File: tb/exp_delay_timer_tb_top.sv
module exp_delay_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    exp_delay_timer dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    function automatic logic [31:0] status_word(input bit done, input int e, input bit busy);
        logic [31:0] w;
        w = '0;
        w[20] = done;
        w[19:17] = 3'(e);
        w[16] = busy;
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Writes a word; returns at the falling edge right after the capture edge
    task automatic wr_word(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    function automatic logic [31:0] go_word(input int e, input logic [31:0] noise);
        logic [31:0] w;
        w = noise;
        w[16] = 1'b1;
        w[19:17] = 3'(e);
        return w;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset status", rd_data, 32'h0);
    endtask

    // Full wait with exact-edge check on done
    task automatic t_delay(input int e, input logic [31:0] noise);
        int n;
        n = 50 << e;
        wr_word(go_word(e, noise));
        chk("R2/R6 start readback", rd_data, status_word(0, e, 1));
        repeat (n - 1) @(negedge clk);
        chk("R3/R4 not yet done", rd_data, status_word(0, e, 1));
        @(negedge clk);
        chk("R3/R4/R5 done on time", rd_data, status_word(1, e, 0));
    endtask

    task automatic t_sticky(input int e);
        repeat (25) @(negedge clk);
        chk("R5 done sticky", rd_data, status_word(1, e, 0));
    endtask

    task automatic t_ignored_idle(input int e);
        wr_word(32'hFFFE_FFFF);
        chk("R8 no-go write while idle", rd_data, status_word(1, e, 0));
    endtask

    task automatic t_ignored_running();
        wr_word(go_word(2, 32'h0));
        repeat (9) @(negedge clk);
        wr_word(32'h000A_0000);
        chk("R8 no-go write while running", rd_data, status_word(0, 2, 1));
        repeat (200 - 11 - 1) @(negedge clk);
        chk("R8 timing kept, not done", rd_data, status_word(0, 2, 1));
        @(negedge clk);
        chk("R8 timing kept, done", rd_data, status_word(1, 2, 0));
    endtask

    task automatic t_restart();
        wr_word(go_word(1, 32'h0));
        repeat (60) @(negedge clk);
        wr_word(go_word(0, 32'h0));
        chk("R7 restart readback", rd_data, status_word(0, 0, 1));
        repeat (49) @(negedge clk);
        chk("R7 restart not yet done", rd_data, status_word(0, 0, 1));
        @(negedge clk);
        chk("R7 restart done", rd_data, status_word(1, 0, 0));
    endtask

    task automatic t_reset_mid();
        wr_word(go_word(3, 32'h0));
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset during wait", rd_data, 32'h0);
        repeat (500) @(negedge clk);
        chk("R1 no done after reset", rd_data, 32'h0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_delay(0, 32'h0);
        t_sticky(0);
        t_ignored_idle(0);
        t_delay(1, 32'hA5A0_5555);
        t_delay(3, 32'h0);
        t_delay(7, 32'h0);
        t_sticky(7);
        t_ignored_running();
        t_restart();
        t_reset_mid();
        finished = 1;
        summary();
        $finish;
    end

endmodule